// File: doc/BRIEF.md
# Sequential Buffer Access Port

This block lets a byte-wide host walk through a 2K-byte internal buffer using only three register offsets. Two of them hold an 11-bit address pointer together with a transfer direction and an auto-advance enable; the third is a data window. A write to the data window goes straight through to the buffer at the pointer address. In read direction the byte at the pointer is fetched in advance, so the first data read after the pointer is set already returns valid data.

With auto-advance on, every data access moves the pointer forward by one, wrapping at the top of the buffer. Block transfers therefore need one pointer setup followed by a run of data accesses. Afterwards the host can read the pointer back to see how many bytes were moved. A small side function converts a page selector (a pair number and an upper-half flag) into the base address of one of eight 256-byte pages. Software uses it to place the pointer at the start of a frame page.

The memory side has a registered address, write enable and write data. Read data is expected one clock after the address, as from an inferred synchronous block RAM. Arbitration of that port with other masters is left to the surrounding logic. Host accesses are single-cycle strobes spaced at least three clocks apart, which leaves room for the two-clock prefetch.

Top module: `seqbuf_port`

## Requirements
- R1: After synchronous reset the pointer is 000h, the direction is write, auto-advance is off, the prefetched byte and host read data are 00h, and the memory write enable is low.
- R2: The register offsets are 2 (pointer high/mode), 3 (pointer low) and 4 (data window). A read of any other offset returns 00h. A write to any other offset changes no pointer, mode or memory state.
- R3: Pointer-high bit 7 sets read direction (1) or write direction (0), bit 6 enables auto-advance, and bits 2..0 load pointer bits 10..8. Reading offset 2 returns {direction, auto-advance, 000b, pointer bits 10..8}.
- R4: Offset 3 loads and reads back pointer bits 7..0.
- R5: A host write to the data window produces, on the next clock, a single-cycle memory write of that byte at the pointer value held before the access.
- R6: With auto-advance on, each data-window read or write advances the pointer by one, wrapping from 7FFh to 000h. With it off, the pointer is unchanged.
- R7: A pointer-high write with bit 7 set fetches the byte at the new pointer, and the next data read returns it.
- R8: A pointer-low write in read direction fetches the byte at the new pointer. In write direction it leaves the memory address and write enable untouched.
- R9: In read direction with auto-advance on, a data read returns the fetched byte and then fetches the byte at the advanced pointer, so successive reads stream consecutive bytes.
- R10: A data read with auto-advance off returns the same fetched byte again and starts no new fetch.
- R11: The page base output equals pair×512 + upper×256, registered one clock after the selector.
- R12: Host read data changes only on the clock that samples a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_i | input | 3 | Register offset |
| host_wdata_i | input | 8 | Host write byte |
| host_wr_i | input | 1 | Single-cycle write strobe |
| host_rd_i | input | 1 | Single-cycle read strobe |
| host_rdata_o | output | 8 | Registered read data |
| mem_addr_o | output | 11 | Buffer address |
| mem_we_o | output | 1 | Buffer write enable |
| mem_wdata_o | output | 8 | Buffer write byte |
| mem_rdata_i | input | 8 | Buffer read byte, one clock after address |
| pg_num_i | input | 2 | Page pair selector |
| pg_upper_i | input | 1 | Upper 256-byte half of the pair |
| pg_base_o | output | 11 | Registered page base address |

## Verification
The bench builds the block with its default widths: an 11-bit pointer, 8-bit data and 256-byte pages. With these values the wrap from 7FFh to 000h can be reached with a single pointer load, in both directions, and the page map can be swept over all eight pages. A bench-side buffer model, preloaded with a computed pattern, feeds prefetches. The byte values in this pattern differ between neighbouring addresses, so a fetch from the wrong address or a missed fetch shows up as a data mismatch.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;

  // Host register offsets; the surrounding decoder depends on these values.
  localparam int          REG_AW     = 3;
  localparam logic [2:0]  OFS_PTR_HI = 3'd2;
  localparam logic [2:0]  OFS_PTR_LO = 3'd3;
  localparam logic [2:0]  OFS_DATA   = 3'd4;

  // Mode bits inside the pointer-high register.
  localparam int BIT_RDDIR = 7;
  localparam int BIT_AINC  = 6;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_HI   = 2'd1,
    RSEL_LO   = 2'd2,
    RSEL_DAT  = 2'd3
  } rsel_e;

endpackage

// File: rtl/seqbuf_decode.sv
module seqbuf_decode
  import seqbuf_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic              dat_wr,
  output logic              dat_rd,
  output logic              reg_rd,
  output rsel_e             rsel
);

  logic rd_ok;

  // A write strobe wins over a simultaneous read strobe.
  assign rd_ok  = rd && !wr;

  assign ld_hi  = wr && (addr == OFS_PTR_HI);
  assign ld_lo  = wr && (addr == OFS_PTR_LO);
  assign dat_wr = wr && (addr == OFS_DATA);
  assign dat_rd = rd_ok && (addr == OFS_DATA);
  assign reg_rd = rd_ok;

  always_comb begin
    unique case (addr)
      OFS_PTR_HI: rsel = RSEL_HI;
      OFS_PTR_LO: rsel = RSEL_LO;
      OFS_DATA:   rsel = RSEL_DAT;
      default:    rsel = RSEL_NONE;
    endcase
  end

endmodule

// File: rtl/seqbuf_ptr.sv
module seqbuf_ptr
  import seqbuf_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          dat_acc,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_nxt,
  output logic          rd_mode_q,
  output logic          ainc_q
);

  localparam int HI_W = AW - DW;

  // Next pointer value, shared with the memory port for the fetch address.
  always_comb begin
    ptr_nxt = ptr_q;
    if (ld_hi) begin
      ptr_nxt[AW-1:DW] = wdata[HI_W-1:0];
    end
    if (ld_lo) begin
      ptr_nxt[DW-1:0] = wdata;
    end
    if (dat_acc && ainc_q) begin
      ptr_nxt = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      rd_mode_q <= 1'b0;
      ainc_q    <= 1'b0;
    end else begin
      ptr_q <= ptr_nxt;
      if (ld_hi) begin
        rd_mode_q <= wdata[BIT_RDDIR];
        ainc_q    <= wdata[BIT_AINC];
      end
    end
  end

endmodule

// File: rtl/seqbuf_memport.sv
module seqbuf_memport #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ptr_cur,
  input  logic [AW-1:0] ptr_nxt,
  input  logic          fetch_req,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] buf_q
);

  // Two-stage tracking of an outstanding fetch: address issued, RAM output valid.
  logic pend_addr_q;
  logic pend_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_we      <= 1'b0;
      mem_wdata   <= '0;
      pend_addr_q <= 1'b0;
      pend_data_q <= 1'b0;
      buf_q       <= '0;
    end else begin
      mem_we      <= 1'b0;
      pend_addr_q <= 1'b0;
      if (dat_wr) begin
        mem_addr  <= ptr_cur;
        mem_we    <= 1'b1;
        mem_wdata <= wdata;
      end else if (fetch_req) begin
        mem_addr    <= ptr_nxt;
        pend_addr_q <= 1'b1;
      end
      pend_data_q <= pend_addr_q;
      if (pend_data_q) begin
        buf_q <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/seqbuf_page_map.sv
module seqbuf_page_map #(
  parameter int AW = 11,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-PW-2:0]  pg_num,
  input  logic              pg_upper,
  output logic [AW-1:0]     base_q
);

  localparam int PAIR_BYTES = 2 ** (PW + 1);
  localparam int HALF_BYTES = 2 ** PW;

  logic [AW-1:0] base_d;

  always_comb begin
    base_d = AW'(pg_num) * AW'(PAIR_BYTES);
    if (pg_upper) begin
      base_d = base_d + AW'(HALF_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/seqbuf_port.sv
module seqbuf_port
  import seqbuf_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic [AW-PW-2:0]  pg_num_i,
  input  logic              pg_upper_i,
  output logic [AW-1:0]     pg_base_o
);

  localparam int HI_W  = AW - DW;
  localparam int PAD_W = DW - 2 - HI_W;

  logic          ld_hi, ld_lo, dat_wr, dat_rd, reg_rd;
  rsel_e         rsel;
  logic [AW-1:0] ptr_q, ptr_nxt;
  logic          rd_mode_q, ainc_q;
  logic          fetch_req;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] hi_view;

  seqbuf_decode u_dec (
    .addr   (host_addr_i),
    .wr     (host_wr_i),
    .rd     (host_rd_i),
    .ld_hi  (ld_hi),
    .ld_lo  (ld_lo),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd),
    .reg_rd (reg_rd),
    .rsel   (rsel)
  );

  seqbuf_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .dat_acc   (dat_wr || dat_rd),
    .wdata     (host_wdata_i),
    .ptr_q     (ptr_q),
    .ptr_nxt   (ptr_nxt),
    .rd_mode_q (rd_mode_q),
    .ainc_q    (ainc_q)
  );

  // Fetch on any pointer load that leaves the port in read direction,
  // and after a streaming read.
  assign fetch_req = (ld_hi && host_wdata_i[BIT_RDDIR])
                   || (ld_lo && rd_mode_q)
                   || (dat_rd && rd_mode_q && ainc_q);

  seqbuf_memport #(.AW(AW), .DW(DW)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .ptr_cur   (ptr_q),
    .ptr_nxt   (ptr_nxt),
    .fetch_req (fetch_req),
    .dat_wr    (dat_wr),
    .wdata     (host_wdata_i),
    .mem_rdata (mem_rdata_i),
    .mem_addr  (mem_addr_o),
    .mem_we    (mem_we_o),
    .mem_wdata (mem_wdata_o),
    .buf_q     (buf_q)
  );

  seqbuf_page_map #(.AW(AW), .PW(PW)) u_pg (
    .clk      (clk),
    .rst      (rst),
    .pg_num   (pg_num_i),
    .pg_upper (pg_upper_i),
    .base_q   (pg_base_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_view = {rd_mode_q, ainc_q, {PAD_W{1'b0}}, ptr_q[AW-1:DW]};
    end else begin : g_nopad
      assign hi_view = {rd_mode_q, ainc_q, ptr_q[AW-1:DW]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata_o <= '0;
    end else if (reg_rd) begin
      unique case (rsel)
        RSEL_HI:  host_rdata_o <= hi_view;
        RSEL_LO:  host_rdata_o <= ptr_q[DW-1:0];
        RSEL_DAT: host_rdata_o <= buf_q;
        default:  host_rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/seqbuf_port_chk.sv
module seqbuf_port_chk
  import seqbuf_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    host_addr_i,
  input logic [DW-1:0] host_wdata_i,
  input logic          host_wr_i,
  input logic          host_rd_i,
  input logic [DW-1:0] host_rdata_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [AW-1:0] ptr_q,
  input logic          rd_mode_q,
  input logic          ainc_q
);

  logic c_dwr, c_drd, c_lo;
  assign c_dwr = host_wr_i && (host_addr_i == OFS_DATA);
  assign c_drd = host_rd_i && !host_wr_i && (host_addr_i == OFS_DATA);
  assign c_lo  = host_wr_i && (host_addr_i == OFS_PTR_LO);

  // R5: data write reaches memory on the next clock with the host byte
  a_r5_write_through: assert property (@(posedge clk) disable iff (rst)
    c_dwr |=> (mem_we_o && mem_wdata_o == $past(host_wdata_i)));

  // R5: memory write enable only follows a data-window write
  a_r5_we_source: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(c_dwr));

  // R6: auto-advance steps the pointer by one
  a_r6_advance: assert property (@(posedge clk) disable iff (rst)
    ((c_dwr || c_drd) && ainc_q) |=> (ptr_q == $past(ptr_q) + AW'(1)));

  // R6: without auto-advance a data access keeps the pointer
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    ((c_dwr || c_drd) && !ainc_q) |=> $stable(ptr_q));

  // R4: pointer low load
  a_r4_low_load: assert property (@(posedge clk) disable iff (rst)
    c_lo |=> (ptr_q[DW-1:0] == $past(host_wdata_i)));

  // R8: a pointer-low load in write direction leaves the memory address alone
  a_r8_no_fetch_wr: assert property (@(posedge clk) disable iff (rst)
    (c_lo && !rd_mode_q && !mem_we_o) |=> $stable(mem_addr_o));

  // R12: read data holds without a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd_i |=> $stable(host_rdata_o));

endmodule

bind seqbuf_port seqbuf_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_rdata_o (host_rdata_o),
  .mem_addr_o   (mem_addr_o),
  .mem_we_o     (mem_we_o),
  .mem_wdata_o  (mem_wdata_o),
  .ptr_q        (ptr_q),
  .rd_mode_q    (rd_mode_q),
  .ainc_q       (ainc_q)
);

// File: tb/seqbuf_port_bench.sv
module seqbuf_port_bench;

  localparam int CLK_NS = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    host_addr_i = '0;
  logic [DW-1:0] host_wdata_i = '0;
  logic          host_wr_i = 1'b0;
  logic          host_rd_i = 1'b0;
  logic [DW-1:0] host_rdata_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_we_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [1:0]    pg_num_i = '0;
  logic          pg_upper_i = 1'b0;
  logic [AW-1:0] pg_base_o;

  seqbuf_port u_seqbuf_port (
    .clk(clk), .rst(rst),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .pg_num_i(pg_num_i), .pg_upper_i(pg_upper_i), .pg_base_o(pg_base_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Buffer model with one clock of read latency.
  logic [DW-1:0] ram [0:DEPTH-1];
  always @(posedge clk) begin
    if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= ram[mem_addr_o];
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model state.
  logic [DW-1:0] exp_mem [0:DEPTH-1];
  logic [AW-1:0] m_ptr = '0;
  logic          m_rd = 1'b0;
  logic          m_ai = 1'b0;
  logic [DW-1:0] m_buf = '0;

  // Scoreboard queues.
  logic [DW-1:0] rq_val[$];
  string         rq_tag[$];
  logic [AW-1:0] wq_addr[$];
  logic [DW-1:0] wq_dat[$];
  string         wq_tag[$];

  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= host_rd_i && !rst;

  // Monitor: host reads.
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rq_val.size() == 0) begin
        chk(1'b0, "R12 unexpected read", int'(host_rdata_o), 0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = rq_val.pop_front();
        t = rq_tag.pop_front();
        chk(host_rdata_o == e, t, int'(host_rdata_o), int'(e));
      end
    end
  end

  // Monitor: memory writes.
  always @(negedge clk) begin
    if (!rst && mem_we_o) begin
      if (wq_addr.size() == 0) begin
        chk(1'b0, "R2 unexpected memory write", int'(mem_addr_o), 0);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        string t;
        ea = wq_addr.pop_front();
        ed = wq_dat.pop_front();
        t  = wq_tag.pop_front();
        chk(mem_addr_o == ea, t, int'(mem_addr_o), int'(ea));
        chk(mem_wdata_o == ed, t, int'(mem_wdata_o), int'(ed));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] ofs, input logic [DW-1:0] d, input string tag);
    case (ofs)
      3'd2: begin
        m_rd = d[7];
        m_ai = d[6];
        m_ptr[AW-1:DW] = d[2:0];
        if (m_rd) m_buf = exp_mem[m_ptr];
      end
      3'd3: begin
        m_ptr[DW-1:0] = d;
        if (m_rd) m_buf = exp_mem[m_ptr];
      end
      3'd4: begin
        wq_addr.push_back(m_ptr);
        wq_dat.push_back(d);
        wq_tag.push_back(tag);
        exp_mem[m_ptr] = d;
        if (m_ai) m_ptr = m_ptr + AW'(1);
      end
      default: ;
    endcase
    @(negedge clk);
    host_addr_i  = ofs;
    host_wdata_i = d;
    host_wr_i    = 1'b1;
    @(negedge clk);
    host_wr_i    = 1'b0;
    idle(3);
  endtask

  task automatic host_rd(input logic [2:0] ofs, input string tag);
    logic [DW-1:0] e;
    case (ofs)
      3'd2: e = {m_rd, m_ai, 3'b000, m_ptr[AW-1:DW]};
      3'd3: e = m_ptr[DW-1:0];
      3'd4: begin
        e = m_buf;
        if (m_ai) begin
          m_ptr = m_ptr + AW'(1);
          if (m_rd) m_buf = exp_mem[m_ptr];
        end
      end
      default: e = '0;
    endcase
    rq_val.push_back(e);
    rq_tag.push_back(tag);
    @(negedge clk);
    host_addr_i = ofs;
    host_rd_i   = 1'b1;
    @(negedge clk);
    host_rd_i   = 1'b0;
    idle(3);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 100000);
    chk(1'b0, "R1 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_rd;
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]     = DW'((i * 37 + 11) ^ (i >> 3));
      exp_mem[i] = DW'((i * 37 + 11) ^ (i >> 3));
    end
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1: reset state
    chk(mem_we_o == 1'b0, "R1 write enable after reset", int'(mem_we_o), 0);
    chk(host_rdata_o == '0, "R1 read data after reset", int'(host_rdata_o), 0);
    host_rd(3'd2, "R1 pointer high after reset");
    host_rd(3'd3, "R1 pointer low after reset");
    host_rd(3'd4, "R1 fetched byte after reset");

    // R5/R6: write direction with auto-advance
    host_wr(3'd2, 8'h41, "R3");
    host_wr(3'd3, 8'h10, "R4");
    host_wr(3'd4, 8'hA5, "R5 write byte 0");
    host_wr(3'd4, 8'h5A, "R5 write byte 1");
    host_wr(3'd4, 8'h3C, "R6 write byte 2");
    host_wr(3'd4, 8'hC3, "R6 write byte 3");
    host_rd(3'd3, "R6 pointer low after four writes");
    host_rd(3'd2, "R3 pointer high readback");

    // R7/R9: read direction streaming
    host_wr(3'd2, 8'hC1, "R7");
    host_wr(3'd3, 8'h10, "R8");
    host_rd(3'd4, "R7 first read after load");
    host_rd(3'd4, "R9 stream byte 1");
    host_rd(3'd4, "R9 stream byte 2");
    host_rd(3'd4, "R9 stream byte 3");
    host_rd(3'd3, "R6 pointer count after reads");

    // R3/R10: read without auto-advance, padding bits ignored
    host_wr(3'd2, 8'hBD, "R3");
    host_rd(3'd2, "R3 mode bits readback with pad");
    host_rd(3'd4, "R10 repeated read first");
    host_rd(3'd4, "R10 repeated read second");
    host_rd(3'd3, "R10 pointer unchanged");

    // R8: pointer-low load in read direction fetches
    host_wr(3'd3, 8'h20, "R8");
    host_rd(3'd4, "R8 fetch after low load");

    // R8: write direction low load does not touch memory address
    host_wr(3'd2, 8'h00, "R8");
    held_addr = mem_addr_o;
    host_wr(3'd3, 8'h33, "R8");
    chk(mem_addr_o == held_addr, "R8 address after write-direction low load",
        int'(mem_addr_o), int'(held_addr));

    // R6: read wrap at the top of the buffer
    host_wr(3'd2, 8'hC7, "R6");
    host_wr(3'd3, 8'hFF, "R6");
    host_rd(3'd4, "R6 read at top address");
    host_rd(3'd4, "R6 read after wrap");
    host_rd(3'd2, "R6 pointer high after wrap");
    host_rd(3'd3, "R6 pointer low after wrap");

    // R6: write wrap
    host_wr(3'd2, 8'h47, "R6");
    host_wr(3'd3, 8'hFF, "R6");
    host_wr(3'd4, 8'h77, "R6 write at top address");
    host_wr(3'd4, 8'h88, "R6 write after wrap");
    host_wr(3'd2, 8'h80, "R7");
    host_wr(3'd3, 8'h00, "R7");
    host_rd(3'd4, "R6 wrapped write landed at zero");

    // R2: unused offsets
    host_wr(3'd1, 8'hFF, "R2");
    host_wr(3'd5, 8'hFF, "R2");
    host_wr(3'd0, 8'hC7, "R2");
    host_rd(3'd2, "R2 pointer high untouched");
    host_rd(3'd3, "R2 pointer low untouched");
    host_rd(3'd5, "R2 unused offset reads zero");
    host_rd(3'd7, "R2 unused offset reads zero");

    // R12: read data holds between strobes
    held_rd = host_rdata_o;
    idle(5);
    chk(host_rdata_o == held_rd, "R12 read data hold", int'(host_rdata_o), int'(held_rd));

    // R11: page base map
    for (int p = 0; p < 8; p++) begin
      logic [AW-1:0] eb;
      @(negedge clk);
      pg_num_i   = 2'(p >> 1);
      pg_upper_i = p[0];
      eb = AW'((p >> 1) * 512 + (p & 1) * 256);
      @(negedge clk);
      chk(pg_base_o == eb, "R11 page base", int'(pg_base_o), int'(eb));
    end

    idle(4);
    chk(rq_val.size() == 0 && wq_addr.size() == 0, "R5 scoreboard drained",
        rq_val.size() + wq_addr.size(), 0);
    summary();
    $finish;
  end

endmodule